// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers eleven interrupt sources of a small 8-bit microcontroller. The sources are a key-scan event, an interval-timer overflow, three external pins, two timer compare matches, a remote-control receiver, A/D conversion completion, a serial port and a watch timer. Each source has a request flag and an enable bit. The CPU reads and writes both through a narrow register bus, where they are split across a high byte and a low byte. A master enable flag gates every request. A trigger-select register sets, for each external pin, whether the pin acts on its level or on an edge. Edges are detected after a synchronizer.

From all sources whose flag and enable bit are both set, the block picks the one with the highest priority. It raises a request to the CPU and presents a 16-bit vector address. Each priority level has a vector two bytes below the level above it. When the CPU strobes accept, the master flag drops so that no other interrupt can nest. If the winner is an edge-configured external pin, its flag is also cleared. A return strobe sets the master flag again.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Priority order, highest first, is source index 0..10: key scan, interval timer, ext0, ext1, timer0, timer1, ext2, remote, A/D, serial, watch timer. The winner is the lowest-index source whose flag and enable bit are both 1.
- R2: `irq_vec` equals 0xFFFC minus twice the winner's index, so ext0 gives 0xFFF8 and the watch timer gives 0xFFE8. When no source is pending and enabled, `irq_vec` is 0xFFFE.
- R3: Register addresses are 0 = request high, 1 = request low, 2 = enable high, 3 = enable low, 4 = trigger select. In the high byte, bit 6-i holds source i for i = 0..6. In the low byte, bit 13-i holds source i for i = 7..10. All of these registers can be written and read back.
- R4: Low-byte bits 2..0, every bit 7, and trigger-select bits 7..6 always read as zero, and writes to them are ignored.
- R5: `irq_req` is 1 only when the master flag is set and some source has both its flag and its enable bit set. `ei_stb` sets the master flag. `di_stb` clears it, and `di_stb` wins over a simultaneous `ei_stb`.
- R6: An `ack_stb` that arrives while `irq_req` is 1 clears the master flag at that edge. `reti_stb` sets it again. An `ack_stb` that arrives while `irq_req` is 0 has no effect.
- R7: On an accepted `ack_stb`, the winner's flag is cleared only if the winner is an external pin whose trigger code is not level. Flags of level-mode pins and of internal sources stay set.
- R8: A one-cycle `src_pulse[i]` sets flag i. A set wins over a software write of 0 and over the accept clear in the same cycle.
- R9: Each external pin k has a 2-bit trigger code at bits 2k+1..2k of register 4. The codes are 00 = level (flag set while the pin is high), 01 = falling edge, 10 = rising edge and 11 = both edges. The flag becomes visible after the third rising clock edge following a pin change.
- R10: After reset, all flags, enable bits, trigger codes and the master flag are 0, `irq_req` is 0 and `irq_vec` is 0xFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for both read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| src_pulse | input | 11 | One-cycle set pulses, one per source, indexed by priority |
| ext_pin | input | 3 | External interrupt pins, asynchronous |
| ei_stb | input | 1 | Enable-interrupts strobe |
| di_stb | input | 1 | Disable-interrupts strobe |
| reti_stb | input | 1 | Return-from-interrupt strobe |
| ack_stb | input | 1 | CPU accept strobe, one cycle |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 16 | Vector address of the current winner |

## Verification
The assertions assume that `ack_stb` is a single-cycle strobe and that `reti_stb` only follows an accepted interrupt. They also assume that `src_pulse` bits last one cycle and that the external pins are low at reset. The stimulus drives all strobes for exactly one clock and changes the pins only between checks. Random register values are masked to the implemented bits before the bench model uses them, and the write-versus-set collisions are created only in directed cases where the expected winner is known.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   localparam int unsigned SRC_COUNT = 11;
   localparam int unsigned HI_COUNT  = 7;
   localparam int unsigned TOP_BIT   = 6;
   localparam int unsigned EXT_COUNT = 3;

   localparam int unsigned A_REQ_HI = 0;
   localparam int unsigned A_REQ_LO = 1;
   localparam int unsigned A_EN_HI  = 2;
   localparam int unsigned A_EN_LO  = 3;
   localparam int unsigned A_TRIG   = 4;

   typedef enum logic [1:0] {
      TRIG_LEVEL = 2'b00,
      TRIG_FALL  = 2'b01,
      TRIG_RISE  = 2'b10,
      TRIG_BOTH  = 2'b11
   } trig_e;

   // Source index served by external pin k.
   function automatic int unsigned ext_src(input int unsigned k);
      case (k)
         0:       return 2;
         1:       return 3;
         default: return 6;
      endcase
   endfunction

   function automatic bit in_hi(input int unsigned s);
      return s < HI_COUNT;
   endfunction

   // Bit position of source s inside its byte.
   function automatic int unsigned byte_pos(input int unsigned s);
      return in_hi(s) ? (TOP_BIT - s) : (TOP_BIT - (s - HI_COUNT));
   endfunction

endpackage

// File: rtl/irqc_pin_trig.sv
module irqc_pin_trig
   import irqc_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  pin,
   input  trig_e mode,
   output logic  set_o
);

   logic [SYNC_STAGES-1:0] sq;
   logic                   prev_q;
   logic                   synced;
   logic                   rise;
   logic                   fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sq     <= '0;
         prev_q <= 1'b0;
      end else begin
         sq[0] <= pin;
         for (int i = 1; i < SYNC_STAGES; i++) begin
            sq[i] <= sq[i-1];
         end
         prev_q <= synced;
      end
   end

   assign synced = sq[SYNC_STAGES-1];
   assign rise   = synced & ~prev_q;
   assign fall   = ~synced & prev_q;

   always_comb begin
      unique case (mode)
         TRIG_LEVEL: set_o = synced;
         TRIG_FALL:  set_o = fall;
         TRIG_RISE:  set_o = rise;
         TRIG_BOTH:  set_o = rise | fall;
         default:    set_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank
   import irqc_pkg::*;
#(
   parameter int unsigned NSRC   = 11,
   parameter int unsigned NEXT   = 3,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [NSRC-1:0]   hw_set,
   input  logic [NSRC-1:0]   ack_clr,
   output logic [NSRC-1:0]   req_q,
   output logic [NSRC-1:0]   en_q,
   output logic [2*NEXT-1:0] trig_q,
   output logic [DATA_W-1:0] rd_data
);

   localparam int unsigned TW = 2 * NEXT;

   logic [NSRC-1:0] req_nxt;
   logic [NSRC-1:0] en_nxt;
   logic wr_req_hi, wr_req_lo, wr_en_hi, wr_en_lo, wr_trig;

   assign wr_req_hi = wr_en && (addr == ADDR_W'(A_REQ_HI));
   assign wr_req_lo = wr_en && (addr == ADDR_W'(A_REQ_LO));
   assign wr_en_hi  = wr_en && (addr == ADDR_W'(A_EN_HI));
   assign wr_en_lo  = wr_en && (addr == ADDR_W'(A_EN_LO));
   assign wr_trig   = wr_en && (addr == ADDR_W'(A_TRIG));

   wire unused_wr_top = wr_data[DATA_W-1];

   // Precedence: accept clear < software write < hardware set.
   always_comb begin
      for (int s = 0; s < NSRC; s++) begin
         req_nxt[s] = req_q[s];
         en_nxt[s]  = en_q[s];
         if (ack_clr[s]) req_nxt[s] = 1'b0;
         if (in_hi(s)) begin
            if (wr_req_hi) req_nxt[s] = wr_data[byte_pos(s)];
            if (wr_en_hi)  en_nxt[s]  = wr_data[byte_pos(s)];
         end else begin
            if (wr_req_lo) req_nxt[s] = wr_data[byte_pos(s)];
            if (wr_en_lo)  en_nxt[s]  = wr_data[byte_pos(s)];
         end
         if (hw_set[s]) req_nxt[s] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= '0;
         en_q   <= '0;
         trig_q <= '0;
      end else begin
         req_q <= req_nxt;
         en_q  <= en_nxt;
         if (wr_trig) trig_q <= wr_data[TW-1:0];
      end
   end

   always_comb begin
      rd_data = '0;
      case (addr)
         ADDR_W'(A_REQ_HI): for (int s = 0; s < HI_COUNT; s++) rd_data[byte_pos(s)] = req_q[s];
         ADDR_W'(A_REQ_LO): for (int s = HI_COUNT; s < NSRC; s++) rd_data[byte_pos(s)] = req_q[s];
         ADDR_W'(A_EN_HI):  for (int s = 0; s < HI_COUNT; s++) rd_data[byte_pos(s)] = en_q[s];
         ADDR_W'(A_EN_LO):  for (int s = HI_COUNT; s < NSRC; s++) rd_data[byte_pos(s)] = en_q[s];
         ADDR_W'(A_TRIG):   rd_data[TW-1:0] = trig_q;
         default:           rd_data = '0;
      endcase
   end

endmodule

// File: rtl/irqc_prio_sel.sv
module irqc_prio_sel #(
   parameter int unsigned NSRC      = 11,
   parameter logic [15:0] VEC_TOP   = 16'hFFFC,
   parameter int unsigned VEC_STEP  = 2,
   parameter logic [15:0] RESET_VEC = 16'hFFFE,
   parameter int unsigned STYLE     = 0
) (
   input  logic [NSRC-1:0] pend,
   output logic            any,
   output logic [NSRC-1:0] grant,
   output logic [15:0]     vec
);

   localparam int unsigned IDX_W = $clog2(NSRC);

   logic [IDX_W-1:0] idx;

   generate
      if (STYLE == 0) begin : g_scan
         // Downward scan: the last hit is the lowest index.
         always_comb begin
            idx = '0;
            for (int i = NSRC - 1; i >= 0; i--) begin
               if (pend[i]) idx = IDX_W'(i);
            end
            grant = pend[idx] ? (NSRC'(1) << idx) : '0;
         end
      end else begin : g_isolate
         // Two's-complement isolation of the lowest set bit.
         always_comb begin
            grant = pend & (~pend + NSRC'(1));
            idx   = '0;
            for (int i = 0; i < NSRC; i++) begin
               if (grant[i]) idx = idx | IDX_W'(i);
            end
         end
      end
   endgenerate

   assign any = |pend;
   assign vec = any ? (VEC_TOP - (16'(idx) * 16'(VEC_STEP))) : RESET_VEC;

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 11,
   parameter int unsigned NUM_EXT     = 3,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [15:0] VEC_TOP     = 16'hFFFC,
   parameter int unsigned VEC_STEP    = 2,
   parameter logic [15:0] RESET_VEC   = 16'hFFFE,
   parameter int unsigned PRIO_STYLE  = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [NUM_SRC-1:0] src_pulse,
   input  logic [NUM_EXT-1:0] ext_pin,
   input  logic               ei_stb,
   input  logic               di_stb,
   input  logic               reti_stb,
   input  logic               ack_stb,
   output logic               irq_req,
   output logic [15:0]        irq_vec
);

   generate
      if (NUM_SRC != SRC_COUNT) begin : g_bad_nsrc
         $error("NUM_SRC must equal the fixed source map size");
      end
      if (NUM_EXT != EXT_COUNT) begin : g_bad_next
         $error("NUM_EXT must equal the fixed external pin count");
      end
      if (DATA_W < 8) begin : g_bad_dw
         $error("DATA_W must hold a full flag byte");
      end
      if (ADDR_W < 3) begin : g_bad_aw
         $error("ADDR_W must reach five registers");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least one");
      end
      if (int'(VEC_TOP) < VEC_STEP * (NUM_SRC - 1)) begin : g_bad_vec
         $error("vector table would wrap below zero");
      end
   endgenerate

   logic [NUM_SRC-1:0]   req_q, en_q, hw_set, ack_clr, grant, edge_mask;
   logic [2*NUM_EXT-1:0] trig_q;
   logic [NUM_EXT-1:0]   pin_set;
   logic                 any_pend;
   logic                 master_q;
   logic                 accept;

   genvar k;
   generate
      for (k = 0; k < NUM_EXT; k++) begin : g_pin
         irqc_pin_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (ext_pin[k]),
            .mode  (trig_e'(trig_q[2*k +: 2])),
            .set_o (pin_set[k])
         );
      end
   endgenerate

   always_comb begin
      hw_set    = src_pulse;
      edge_mask = '0;
      for (int p = 0; p < NUM_EXT; p++) begin
         hw_set[ext_src(p)]    = src_pulse[ext_src(p)] | pin_set[p];
         edge_mask[ext_src(p)] = (trig_q[2*p +: 2] != TRIG_LEVEL);
      end
   end

   assign accept  = ack_stb & irq_req;
   assign ack_clr = accept ? (grant & edge_mask) : '0;

   irqc_flag_bank #(
      .NSRC   (NUM_SRC),
      .NEXT   (NUM_EXT),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_we),
      .addr    (reg_addr),
      .wr_data (reg_wdata),
      .hw_set  (hw_set),
      .ack_clr (ack_clr),
      .req_q   (req_q),
      .en_q    (en_q),
      .trig_q  (trig_q),
      .rd_data (reg_rdata)
   );

   irqc_prio_sel #(
      .NSRC      (NUM_SRC),
      .VEC_TOP   (VEC_TOP),
      .VEC_STEP  (VEC_STEP),
      .RESET_VEC (RESET_VEC),
      .STYLE     (PRIO_STYLE)
   ) u_prio (
      .pend  (req_q & en_q),
      .any   (any_pend),
      .grant (grant),
      .vec   (irq_vec)
   );

   // Master flag: accept beats disable, disable beats enable or return.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  master_q <= 1'b0;
      else if (accept)             master_q <= 1'b0;
      else if (di_stb)             master_q <= 1'b0;
      else if (ei_stb || reti_stb) master_q <= 1'b1;
   end

   assign irq_req = master_q & any_pend;

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
   parameter int unsigned NSRC     = 11,
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned DATA_W   = 8,
   parameter logic [15:0] VEC_TOP  = 16'hFFFC,
   parameter int unsigned VEC_STEP = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack_stb,
   input logic              di_stb,
   input logic              reti_stb,
   input logic              irq_req,
   input logic [15:0]       irq_vec,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [NSRC-1:0]   src_pulse,
   input logic [NSRC-1:0]   req_q,
   input logic              master_q
);

   localparam logic [15:0] VEC_LOW = VEC_TOP - 16'(VEC_STEP * (NSRC - 1));

   p_accept_masks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_stb && irq_req) |=> !irq_req);

   p_disable_masks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      di_stb |=> !irq_req);

   p_return_restores_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_stb && !di_stb && !(ack_stb && irq_req)) |=> master_q);

   p_vec_in_table_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_vec[0] == 1'b0 && irq_vec <= VEC_TOP && irq_vec >= VEC_LOW));

   p_lo_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(1) || reg_addr == ADDR_W'(3)) |-> (reg_rdata[2:0] == 3'b000));

   genvar s;
   generate
      for (s = 0; s < NSRC; s++) begin : g_set
         p_pulse_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
            src_pulse[s] |=> req_q[s]);
      end
   endgenerate

endmodule

bind irq_vector_ctrl irqc_chk #(
   .NSRC     (NUM_SRC),
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .VEC_TOP  (VEC_TOP),
   .VEC_STEP (VEC_STEP)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ack_stb   (ack_stb),
   .di_stb    (di_stb),
   .reti_stb  (reti_stb),
   .irq_req   (irq_req),
   .irq_vec   (irq_vec),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata),
   .src_pulse (src_pulse),
   .req_q     (req_q),
   .master_q  (master_q)
);

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [10:0] src_pulse = '0;
   logic [2:0]  ext_pin = '0;
   logic        ei_stb = 1'b0, di_stb = 1'b0, reti_stb = 1'b0, ack_stb = 1'b0;
   logic        irq_req;
   logic [15:0] irq_vec;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   irq_vector_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_pulse(src_pulse),
      .ext_pin(ext_pin), .ei_stb(ei_stb), .di_stb(di_stb), .reti_stb(reti_stb),
      .ack_stb(ack_stb), .irq_req(irq_req), .irq_vec(irq_vec)
   );

   // Flag vector from the two register bytes (R3 bit map).
   function automatic logic [10:0] unpack(input logic [7:0] hi, input logic [7:0] lo);
      logic [10:0] f;
      for (int s = 0; s < 7; s++)  f[s] = hi[6-s];
      for (int s = 7; s < 11; s++) f[s] = lo[13-s];
      return f;
   endfunction

   function automatic logic [15:0] exp_vec(input logic [10:0] p);
      for (int i = 0; i < 11; i++) if (p[i]) return 16'hFFFC - 16'(2*i);
      return 16'hFFFE;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic strobe(input bit e, input bit di, input bit r, input bit a);
      @(negedge clk);
      ei_stb = e; di_stb = di; reti_stb = r; ack_stb = a;
      @(negedge clk);
      ei_stb = 0; di_stb = 0; reti_stb = 0; ack_stb = 0;
   endtask

   task automatic pulse(input int s);
      @(negedge clk);
      src_pulse[s] = 1'b1;
      @(negedge clk);
      src_pulse = '0;
   endtask

   task automatic clear_all();
      wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'h00);
      wr(3'd0, 8'h00); wr(3'd1, 8'h00);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic [7:0] eh, el, rh, rl;
      logic [10:0] pend;
      void'($urandom(32'd20250101));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), d);
         check("R10 reg reset", d, 8'h00);
      end
      check("R10 irq_req reset", irq_req, 1'b0);
      check("R10 vec reset", irq_vec, 16'hFFFE);

      // R3/R4: readback and unused bits
      wr(3'd0, 8'hFF); rd(3'd0, d); check("R3 req hi readback", d, 8'h7F);
      wr(3'd1, 8'hFF); rd(3'd1, d); check("R4 req lo pad", d, 8'h78);
      wr(3'd2, 8'hA5); rd(3'd2, d); check("R3 en hi readback", d, 8'h25);
      wr(3'd3, 8'hFF); rd(3'd3, d); check("R4 en lo pad", d, 8'h78);
      wr(3'd4, 8'hFF); rd(3'd4, d); check("R4 trig pad", d, 8'h3F);
      clear_all();
      strobe(1, 0, 0, 0);

      // R1/R2: random patterns against the model
      for (int it = 0; it < 60; it++) begin
         eh = 8'($urandom) & 8'h7F; el = 8'($urandom) & 8'h78;
         rh = 8'($urandom) & 8'h7F; rl = 8'($urandom) & 8'h78;
         if (it % 4 == 0) begin rh = rh & 8'h01; eh = eh & 8'h03; end
         wr(3'd2, eh); wr(3'd3, el); wr(3'd0, rh); wr(3'd1, rl);
         pend = unpack(rh, rl) & unpack(eh, el);
         check("R1 random irq_req", irq_req, |pend);
         check("R2 random vector", irq_vec, exp_vec(pend));
         rd(3'd1, d); check("R3 random req lo", d, rl);
      end

      // R1/R2 directed ends of the table
      wr(3'd2, 8'h7F); wr(3'd3, 8'h78); wr(3'd0, 8'h7F); wr(3'd1, 8'h78);
      check("R1 all pending key scan wins", irq_vec, 16'hFFFC);
      wr(3'd0, 8'h00); wr(3'd1, 8'h08);
      check("R2 watch timer vector", irq_vec, 16'hFFE8);
      wr(3'd1, 8'h40);
      check("R2 remote vector", irq_vec, 16'hFFEE);

      // R5: master flag strobes
      clear_all();
      wr(3'd2, 8'h40); wr(3'd0, 8'h40);
      check("R5 pending with master set", irq_req, 1'b1);
      strobe(0, 1, 0, 0);
      check("R5 di masks", irq_req, 1'b0);
      strobe(1, 1, 0, 0);
      check("R5 di beats ei", irq_req, 1'b0);
      check("R2 vector while masked", irq_vec, 16'hFFFC);
      strobe(1, 0, 0, 0);
      check("R5 ei restores", irq_req, 1'b1);
      wr(3'd2, 8'h00);
      check("R5 enable bit gates", irq_req, 1'b0);
      wr(3'd2, 8'h40);

      // R6: accept and return
      strobe(0, 0, 0, 1);
      check("R6 accept drops request", irq_req, 1'b0);
      rd(3'd0, d); check("R7 internal flag kept", d, 8'h40);
      strobe(0, 0, 1, 0);
      check("R6 return restores", irq_req, 1'b1);
      wr(3'd2, 8'h00);
      strobe(0, 0, 0, 1);
      wr(3'd2, 8'h40);
      check("R6 idle accept ignored", irq_req, 1'b1);

      // R7: edge-mode ext0 auto-clear
      clear_all();
      wr(3'd4, 8'h02); wr(3'd2, 8'h10);
      ext_pin[0] = 1'b1;
      repeat (2) @(negedge clk);
      rd(3'd0, d); check("R9 latency before third edge", d, 8'h00);
      @(negedge clk);
      rd(3'd0, d); check("R9 rising edge sets ext0", d, 8'h10);
      check("R2 ext0 vector", irq_vec, 16'hFFF8);
      strobe(0, 0, 0, 1);
      rd(3'd0, d); check("R7 edge flag cleared on accept", d, 8'h00);
      ext_pin[0] = 1'b0;
      repeat (4) @(negedge clk);
      rd(3'd0, d); check("R9 falling ignored in rise mode", d, 8'h00);
      strobe(0, 0, 1, 0);

      // R7: level-mode ext1 stays set
      wr(3'd2, 8'h08);
      ext_pin[1] = 1'b1;
      repeat (3) @(negedge clk);
      check("R9 level sets ext1", irq_vec, 16'hFFF6);
      strobe(0, 0, 0, 1);
      rd(3'd0, d); check("R7 level flag kept", d, 8'h08);
      ext_pin[1] = 1'b0;
      repeat (4) @(negedge clk);
      wr(3'd0, 8'h00);
      rd(3'd0, d); check("R7 level flag cleared by write", d, 8'h00);
      strobe(0, 0, 1, 0);

      // R7: timer flag not auto-cleared
      wr(3'd2, 8'h04);
      pulse(4);
      check("R8 timer0 pulse vector", irq_vec, 16'hFFF4);
      strobe(0, 0, 0, 1);
      rd(3'd0, d); check("R7 timer flag kept", d, 8'h04);
      strobe(0, 0, 1, 0);

      // R9: falling and both-edge codes on ext2
      clear_all();
      wr(3'd4, 8'h10);
      ext_pin[2] = 1'b1;
      repeat (4) @(negedge clk);
      rd(3'd0, d); check("R9 rise ignored in fall mode", d, 8'h00);
      ext_pin[2] = 1'b0;
      repeat (3) @(negedge clk);
      rd(3'd0, d); check("R9 falling sets ext2", d, 8'h01);
      wr(3'd0, 8'h00); wr(3'd4, 8'h30);
      ext_pin[2] = 1'b1;
      repeat (3) @(negedge clk);
      rd(3'd0, d); check("R9 both mode rise", d, 8'h01);
      wr(3'd0, 8'h00);
      ext_pin[2] = 1'b0;
      repeat (3) @(negedge clk);
      rd(3'd0, d); check("R9 both mode fall", d, 8'h01);

      // R8: set wins over software clear and accept clear
      clear_all();
      wr(3'd1, 8'h20);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h00; src_pulse[8] = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; src_pulse = '0;
      rd(3'd1, d); check("R8 set beats write clear", d, 8'h20);
      pulse(9);
      rd(3'd1, d); check("R8 serial pulse sets", d, 8'h30);
      wr(3'd1, 8'h00);
      wr(3'd4, 8'h02); wr(3'd2, 8'h10);
      pulse(2);
      check("R8 ext0 pending", irq_req, 1'b1);
      @(negedge clk);
      ack_stb = 1'b1; src_pulse[2] = 1'b1;
      @(negedge clk);
      ack_stb = 1'b0; src_pulse = '0;
      rd(3'd0, d); check("R8 set beats accept clear", d, 8'h10);
      check("R6 master cleared by accept", irq_req, 1'b0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule